// File: doc/BRIEF.md
# Nibble-Mode Parallel Byte Receiver

This block receives bytes from a peer that sends them four bits at a time over a bank of status lines. The lines arrive as a 5-bit vector. The low four bits carry a data nibble. Bit 4 is the peer's strobe, which the peer toggles once for each nibble. The block sees the strobe as an active-low busy line. Every input first passes through a two-flop synchronizer and then a two-sample stability filter. The control logic acts only on the filtered values.

Each nibble is a stop-and-wait exchange. When the busy line falls, the receiver keeps the low nibble and raises its acknowledge output. When the busy line rises again, it keeps the high nibble and drops the acknowledge. It then presents the byte `{high, low}` on a valid/ready output and holds it there until the consumer accepts it.

While the block is idle, a falling edge on line 3 (the peer's wake line) raises a one-cycle interrupt request. If the second half of an exchange does not arrive in time, the receiver reports an error. It then clears its acknowledge and waits for the peer to release the busy line before it starts again.

Top module: `nibble_rx`

## Requirements
- R1: During and right after synchronous reset, `ack_out`, `out_valid`, `irq` and `err` are all 0.
- R2: In the idle state, when the filtered `lines_in[4]` reads 0, the receiver stores `lines_in[3:0]` as the low nibble and drives `ack_out` to 1.
- R3: While `ack_out` is 1, when the filtered `lines_in[4]` reads 1, the receiver stores `lines_in[3:0]` as the high nibble, drives `ack_out` to 0, and presents `out_data = {high, low}` with `out_valid` = 1.
- R4: `out_valid` and `out_data` hold steady until a cycle with `out_ready` = 1. During that time `ack_out` stays 0 even if the busy line falls.
- R5: A change on `lines_in` that lasts a single clock cycle has no effect: it sets neither `ack_out` nor `irq`.
- R6: A falling edge on the filtered `lines_in[3]` in the idle state, with `lines_in[4]` at 1, pulses `irq` for exactly one cycle. A rising edge does not.
- R7: If `lines_in[4]` does not return to 1 within TIMEOUT_CYCLES cycles after `ack_out` rises, the receiver:
  - pulses `err` for one cycle, exactly TIMEOUT_CYCLES cycles after `ack_out` rises;
  - drives `ack_out` to 0;
  - produces no byte.
- R8: After a timeout, the receiver ignores the busy line until it has read 1. After that, it accepts bytes normally.
- R9: When `lines_in[4]` changes at the idle state, `ack_out` changes on the fifth rising clock edge after the change and not before. The delay comes from two synchronizer stages, two filter samples and the state register.
- R10: A nibble change made in the same cycle as the busy fall never causes `irq`, because capture takes priority over wake detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_in | input | 5 | Asynchronous status lines: [3:0] data nibble, [4] busy (active low) |
| out_ready | input | 1 | Consumer accepts the byte on `out_data` |
| ack_out | output | 1 | Acknowledge line driven back to the peer |
| out_data | output | 8 | Assembled byte `{high nibble, low nibble}` |
| out_valid | output | 1 | `out_data` holds a byte not yet accepted |
| irq | output | 1 | One-cycle wake request |
| err | output | 1 | One-cycle timeout indication |

## Verification
The assertions check several rules on every cycle:
- `ack_out` rises only after the filtered busy line has been seen low.
- `ack_out` falls only when the busy line is seen high or on a timeout.
- A new byte appears exactly as the acknowledge drops.
- `out_data` stays stable under backpressure.
- `irq` and `err` occur only with no transfer in progress.

Other behaviour can only be shown by the bench's scenarios:
- byte assembly for distinct data patterns;
- the exact five-edge input latency;
- rejection of single-cycle glitches;
- the precise timeout count;
- recovery after a timeout.

// File: rtl/nibble_rx_pkg.sv
package nibble_rx_pkg;
  localparam int LINE_W = 5;
  localparam int NIB_W  = 4;
  localparam int BUSY_BIT = 4;
  localparam int WAKE_BIT = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_HOLD,
    ST_RESYNC
  } rx_state_t;
endpackage

// File: rtl/nrx_sync.sv
module nrx_sync #(
  parameter int          W       = 5,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nrx_filter.sv
module nrx_filter #(
  parameter int          W       = 5,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] last;

  // A value passes only once two consecutive samples agree.
  always_ff @(posedge clk) begin
    if (rst) begin
      last <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      last <= d;
      if (d == last) q <= d;
    end
  end
endmodule

// File: rtl/nrx_ctrl.sv
module nrx_ctrl
  import nibble_rx_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] lines_f,
  input  logic              out_ready,
  output logic              ack_out,
  output logic [2*NIB_W-1:0] out_data,
  output logic              out_valid,
  output logic              irq,
  output logic              err
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  rx_state_t        state;
  logic [NIB_W-1:0] lo_nib;
  logic [CNT_W-1:0] cnt;
  logic             wake_prev;
  logic             busy;
  logic [NIB_W-1:0] nib;

  assign busy = lines_f[BUSY_BIT];
  assign nib  = lines_f[NIB_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ack_out   <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      irq       <= 1'b0;
      err       <= 1'b0;
      lo_nib    <= '0;
      cnt       <= '0;
      wake_prev <= 1'b1;
    end else begin
      irq       <= 1'b0;
      err       <= 1'b0;
      wake_prev <= lines_f[WAKE_BIT];
      case (state)
        ST_IDLE: begin
          if (!busy) begin
            lo_nib  <= nib;
            ack_out <= 1'b1;
            cnt     <= '0;
            state   <= ST_WAIT_HI;
          end else if (wake_prev && !lines_f[WAKE_BIT]) begin
            irq <= 1'b1;
          end
        end
        ST_WAIT_HI: begin
          if (busy) begin
            out_data  <= {nib, lo_nib};
            out_valid <= 1'b1;
            ack_out   <= 1'b0;
            state     <= ST_HOLD;
          end else if (cnt == CNT_LAST) begin
            err     <= 1'b1;
            ack_out <= 1'b0;
            state   <= ST_RESYNC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: begin
          if (busy) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/nibble_rx.sv
module nibble_rx
  import nibble_rx_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] lines_in,
  input  logic       out_ready,
  output logic       ack_out,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       irq,
  output logic       err
);
  logic [LINE_W-1:0] lines_s;
  logic [LINE_W-1:0] lines_f;

  nrx_sync #(.W(LINE_W), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d(lines_in), .q(lines_s)
  );

  nrx_filter #(.W(LINE_W), .RST_VAL('1)) u_filt (
    .clk(clk), .rst(rst), .d(lines_s), .q(lines_f)
  );

  nrx_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .lines_f(lines_f), .out_ready(out_ready),
    .ack_out(ack_out), .out_data(out_data), .out_valid(out_valid),
    .irq(irq), .err(err)
  );
endmodule

// File: rtl/nibble_rx_chk.sv
module nibble_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy_f,
  input logic       ack_out,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       irq,
  input logic       err
);
  // R2
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_out) |-> !$past(busy_f));

  // R3
  ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_out) |-> ($past(busy_f) || err));

  // R3
  byte_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $fell(ack_out));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  no_ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !ack_out);

  // R6
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!ack_out && !out_valid));

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!ack_out && !out_valid));
endmodule

bind nibble_rx nibble_rx_chk u_chk (
  .clk(clk), .rst(rst), .busy_f(lines_f[4]), .ack_out(ack_out),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
  .irq(irq), .err(err)
);

// File: tb/tb_nibble_rx.sv
module tb_nibble_rx;
  localparam int TO = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] lines_in = 5'h1F;
  logic       out_ready = 1'b1;
  logic       ack_out, out_valid, irq, err;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  byte unsigned exp_q[$];

  always #4 clk = ~clk;

  nibble_rx #(.TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rst(rst), .lines_in(lines_in), .out_ready(out_ready),
    .ack_out(ack_out), .out_data(out_data), .out_valid(out_valid),
    .irq(irq), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected bytes as they are accepted.
  always @(negedge clk) begin
    if (!rst && irq) irq_cnt++;
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", out_data, 0);
      else begin
        byte unsigned e;
        e = exp_q.pop_front();
        chk(out_data == e, "R3 byte", out_data, e);
      end
    end
  end

  task automatic wait_ack(input logic v, input string tag);
    for (int i = 0; i < 300; i++) begin
      if (ack_out == v) return;
      @(negedge clk);
    end
    chk(1'b0, tag, ack_out, v);
  endtask

  task automatic send_byte(input byte unsigned b);
    exp_q.push_back(b);
    @(negedge clk);
    lines_in = {1'b0, b[3:0]};
    wait_ack(1'b1, "R2 ack rise");
    @(negedge clk);
    lines_in = {1'b1, b[7:4]};
    wait_ack(1'b0, "R3 ack drop");
  endtask

  task automatic drain;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int irq_before;
    int n;
    bit seen;
    repeat (4) @(negedge clk);
    chk({ack_out, out_valid, irq, err} == 4'b0, "R1 in reset", {ack_out, out_valid, irq, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({ack_out, out_valid, irq, err} == 4'b0, "R1 after reset", {ack_out, out_valid, irq, err}, 0);
    repeat (3) @(negedge clk);

    // R9 latency: ack changes on the fifth rising edge
    exp_q.push_back(8'hA5);
    lines_in = 5'h05;
    repeat (4) @(negedge clk);
    chk(ack_out == 1'b0, "R9 ack before edge 5", ack_out, 0);
    @(negedge clk);
    chk(ack_out == 1'b1, "R9 ack at edge 5", ack_out, 1);
    lines_in = 5'h1A;
    wait_ack(1'b0, "R3 ack drop");
    drain();

    // R2 R3 R10 several patterns
    irq_before = irq_cnt;
    send_byte(8'h00);
    send_byte(8'hFF);
    send_byte(8'h3C);
    send_byte(8'h81);
    send_byte(8'h7E);
    drain();
    chk(irq_cnt == irq_before, "R10 no irq during bytes", irq_cnt - irq_before, 0);

    // R4 backpressure
    out_ready = 1'b0;
    exp_q.push_back(8'h96);
    @(negedge clk); lines_in = 5'h06;
    wait_ack(1'b1, "R2 ack rise");
    @(negedge clk); lines_in = 5'h19;
    wait_ack(1'b0, "R3 ack drop");
    repeat (20) @(negedge clk);
    chk(out_valid == 1'b1, "R4 valid held", out_valid, 1);
    chk(out_data == 8'h96, "R4 data held", out_data, 8'h96);
    exp_q.push_back(8'hD2);
    lines_in = 5'h02;
    repeat (15) @(negedge clk);
    chk(ack_out == 1'b0, "R4 no ack while held", ack_out, 0);
    out_ready = 1'b1;
    wait_ack(1'b1, "R4 ack after accept");
    @(negedge clk); lines_in = 5'h1D;
    wait_ack(1'b0, "R3 ack drop");
    drain();

    // R5 single-cycle glitches
    irq_before = irq_cnt;
    @(negedge clk); lines_in = 5'h0D;
    @(negedge clk); lines_in = 5'h1D;
    @(negedge clk); lines_in = 5'h15;
    @(negedge clk); lines_in = 5'h1D;
    repeat (10) @(negedge clk);
    chk(ack_out == 1'b0, "R5 busy glitch ignored", ack_out, 0);
    chk(irq_cnt == irq_before, "R5 wake glitch ignored", irq_cnt - irq_before, 0);

    // R6 wake
    lines_in = 5'h15;
    repeat (10) @(negedge clk);
    chk(irq_cnt == irq_before + 1, "R6 one irq on fall", irq_cnt - irq_before, 1);
    lines_in = 5'h1D;
    repeat (10) @(negedge clk);
    chk(irq_cnt == irq_before + 1, "R6 no irq on rise", irq_cnt - irq_before, 1);

    // R7 timeout
    lines_in = 5'h03;
    wait_ack(1'b1, "R7 ack rise");
    n = 0; seen = 0;
    for (int i = 0; i < 4 * TO && !seen; i++) begin
      @(negedge clk);
      n++;
      if (err) seen = 1;
    end
    chk(seen, "R7 err pulse", seen, 1);
    chk(n == TO, "R7 timeout count", n, TO);
    chk(ack_out == 1'b0 && out_valid == 1'b0, "R7 ack cleared no byte", {ack_out, out_valid}, 0);
    @(negedge clk);
    chk(err == 1'b0, "R7 err one cycle", err, 0);

    // R8 recovery
    repeat (20) @(negedge clk);
    chk(ack_out == 1'b0, "R8 busy low ignored", ack_out, 0);
    lines_in = 5'h1F;
    repeat (10) @(negedge clk);
    send_byte(8'h5A);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule